// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Generator

This block produces the instruction fetch address for a 32-bit pipelined processor that has one branch delay slot. Each cycle it looks at the instruction word fetched from the current address and at a taken flag from the condition logic. From these it decides the next fetch address. Plain instructions step the address by four. A conditional branch that is taken, or any absolute jump, does not squash the instruction that follows it. That slot instruction is fetched and runs as normal, and the fetch right after it goes to the computed target. A taken transfer therefore adds no bubble cycles.

The control is a two-state machine. In `ST_RUN` the unit fetches in sequence and decodes each incoming word. The transition `ST_RUN -> ST_SLOT` happens on an unstalled cycle whose word is a taken branch or a jump. At that point the target is latched while the delay-slot address is issued. The transition `ST_SLOT -> ST_RUN` happens on the next unstalled cycle and issues the latched target. Any word presented while in `ST_SLOT` is not decoded. A stall keeps the state, the address and the latched target where they are, so a stall can never lose a pending redirect.

Top module: `delay_pc_unit`

## Requirements
- R1: While reset is asserted, and until the first unstalled clock edge after it, `fetch_pc` equals the reset vector (default 32'h1FC0_0000).
- R2: In the sequential state, an unstalled edge with a word that is not a transfer (opcode field bits 31:26 neither 6'b000100 nor 6'b000010) moves `fetch_pc` to `fetch_pc + 4`.
- R3: A word with opcode 6'b000100 and `take_cond` = 1 is a taken branch. The next address is the slot address `pc+4`. The address after that is `(pc+4) + (sign-extended bits 15:0 << 2)`, so both forward and backward displacements are reached.
- R4: A word with opcode 6'b000100 and `take_cond` = 0 causes no redirect. Fetch continues `pc+4`, `pc+8`.
- R5: A word with opcode 6'b000010 always transfers. After the slot address `pc+4`, the unit fetches `{(pc+4)[31:28], bits 25:0, 2'b00}`.
- R6: `take_cond` has no effect unless the opcode is the branch opcode.
- R7: A transfer word that arrives in the delay slot is not decoded. The fetch after the slot is the pending target, followed by sequential fetch from there.
- R8: While `stall` is high, `fetch_pc`, the state and any pending target hold their values. A word presented under stall is not decoded.
- R9: Bits 1:0 of `fetch_pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freezes the address and any pending redirect |
| instr | input | 32 | Instruction word fetched from the current `fetch_pc` |
| take_cond | input | 1 | Branch condition result for `instr` |
| fetch_pc | output | 32 | Address of the instruction being fetched |

## Verification
The assertions check on every cycle that the address stays word aligned and that a stall freezes both the address and the state. They also check that any unstalled cycle in the sequential state steps the address by exactly four, which covers the delay-slot fetch. Finally they check that the slot state never outlasts one unstalled cycle. Only the bench scenarios can show that the target arithmetic is correct: forward and backward branch displacements, jump upper-bit splicing, a transfer ignored inside the slot, a branch ignored under stall, and a redirect that survives a stall in the slot.

// File: rtl/delay_pc_pkg.sv
package delay_pc_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_SLOT = 1'b1
    } pcst_t;

    typedef enum logic [1:0] {
        XF_NONE   = 2'd0,
        XF_BRANCH = 2'd1,
        XF_JUMP   = 2'd2
    } xfer_t;

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
    import delay_pc_pkg::*;
#(
    parameter int           OPC_W     = 6,
    parameter logic [5:0]   OP_BRANCH = 6'b000100,
    parameter logic [5:0]   OP_JUMP   = 6'b000010
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic             take_cond,
    output xfer_t            kind
);

    always_comb begin
        kind = XF_NONE;
        if (opcode == OP_JUMP[OPC_W-1:0]) begin
            kind = XF_JUMP;
        end else if (opcode == OP_BRANCH[OPC_W-1:0] && take_cond) begin
            kind = XF_BRANCH;
        end
    end

endmodule

// File: rtl/target_calc.sv
module target_calc
    import delay_pc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int JIDX_W = 26
) (
    input  logic [ADDR_W-1:0] slot_pc,
    input  logic [JIDX_W-1:0] field,
    input  xfer_t             kind,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - DISP_W - 2;
    localparam int HI_W  = ADDR_W - JIDX_W - 2;

    logic [DISP_W-1:0] disp;
    logic [ADDR_W-1:0] disp_bytes;
    logic [ADDR_W-1:0] br_target;
    logic [ADDR_W-1:0] jp_target;

    assign disp       = field[DISP_W-1:0];
    assign disp_bytes = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    assign br_target  = slot_pc + disp_bytes;
    assign jp_target  = {slot_pc[ADDR_W-1 -: HI_W], field, 2'b00};

    always_comb begin
        unique case (kind)
            XF_JUMP:   target = jp_target;
            XF_BRANCH: target = br_target;
            default:   target = slot_pc;
        endcase
    end

endmodule

// File: rtl/pc_fsm.sv
module pc_fsm
    import delay_pc_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter logic [31:0]      RESET_VEC = 32'h1FC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  xfer_t             kind,
    input  logic [ADDR_W-1:0] slot_pc,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc_q,
    output pcst_t             st_q
);

    pcst_t             st_n;
    logic [ADDR_W-1:0] pc_n;
    logic [ADDR_W-1:0] tgt_q;
    logic [ADDR_W-1:0] tgt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            pc_q  <= RESET_VEC[ADDR_W-1:0];
            tgt_q <= '0;
        end else begin
            st_q  <= st_n;
            pc_q  <= pc_n;
            tgt_q <= tgt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        pc_n  = pc_q;
        tgt_n = tgt_q;
        unique case (st_q)
            ST_RUN: begin
                if (!stall) begin
                    pc_n = slot_pc;
                    if (kind != XF_NONE) begin
                        tgt_n = target;
                        st_n  = ST_SLOT;
                    end
                end
            end
            ST_SLOT: begin
                if (!stall) begin
                    pc_n = tgt_q;
                    st_n = ST_RUN;
                end
            end
        endcase
    end

endmodule

// File: rtl/delay_pc_unit.sv
module delay_pc_unit
    import delay_pc_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          INSN_W    = 32,
    parameter int          OPC_W     = 6,
    parameter int          DISP_W    = 16,
    parameter logic [5:0]  OP_BRANCH = 6'b000100,
    parameter logic [5:0]  OP_JUMP   = 6'b000010,
    parameter logic [31:0] RESET_VEC = 32'h1FC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [INSN_W-1:0] instr,
    input  logic              take_cond,
    output logic [ADDR_W-1:0] fetch_pc
);

    localparam int JIDX_W = INSN_W - OPC_W;

    xfer_t             kind;
    pcst_t             run_state;
    logic [ADDR_W-1:0] slot_pc;
    logic [ADDR_W-1:0] target;

    assign slot_pc = fetch_pc + ADDR_W'(4);

    xfer_decode #(
        .OPC_W     (OPC_W),
        .OP_BRANCH (OP_BRANCH),
        .OP_JUMP   (OP_JUMP)
    ) u_dec (
        .opcode    (instr[INSN_W-1 -: OPC_W]),
        .take_cond (take_cond),
        .kind      (kind)
    );

    target_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .JIDX_W (JIDX_W)
    ) u_tgt (
        .slot_pc (slot_pc),
        .field   (instr[JIDX_W-1:0]),
        .kind    (kind),
        .target  (target)
    );

    pc_fsm #(
        .ADDR_W    (ADDR_W),
        .RESET_VEC (RESET_VEC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .kind    (kind),
        .slot_pc (slot_pc),
        .target  (target),
        .pc_q    (fetch_pc),
        .st_q    (run_state)
    );

endmodule

// File: rtl/delay_pc_chk.sv
module delay_pc_chk
    import delay_pc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic [ADDR_W-1:0] fetch_pc,
    input pcst_t             st
);

    // R9
    pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pc[1:0] == 2'b00);

    // R8
    pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(fetch_pc));

    // R8
    state_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(st));

    // R2
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && st == ST_RUN) |=> fetch_pc == $past(fetch_pc) + ADDR_W'(4));

    // R7
    slot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && st == ST_SLOT) |=> st == ST_RUN);

endmodule

bind delay_pc_unit delay_pc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .fetch_pc (fetch_pc),
    .st       (run_state)
);

// File: tb/sim_delay_pc_unit.sv
`timescale 1ns/1ps
module sim_delay_pc_unit;

    localparam logic [31:0] RVEC = 32'h1FC0_0000;
    localparam logic [31:0] NOP  = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] instr = NOP;
    logic        take_cond = 1'b0;
    logic [31:0] fetch_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_pc = RVEC;
    logic        m_pend = 1'b0;
    logic [31:0] m_tgt = '0;

    always #5 clk = ~clk;

    delay_pc_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .instr     (instr),
        .take_cond (take_cond),
        .fetch_pc  (fetch_pc)
    );

    function automatic logic [31:0] br(input logic [15:0] imm);
        return {6'b000100, 10'd0, imm};
    endfunction

    function automatic logic [31:0] jmp(input logic [25:0] idx);
        return {6'b000010, idx};
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        n_chk++;
        if (fetch_pc !== exp) begin
            n_bad++;
            $display("FAIL %s: fetch_pc=%h expected=%h", tag, fetch_pc, exp);
        end
    endtask

    // One clock with given inputs; reference model from the requirements.
    task automatic step(input logic [31:0] w, input logic tk,
                        input logic st, input string tag);
        instr = w; take_cond = tk; stall = st;
        @(posedge clk);
        if (!st) begin
            if (m_pend) begin
                m_pc = m_tgt; m_pend = 1'b0;
            end else begin
                if (w[31:26] == 6'b000100 && tk) begin
                    m_tgt = m_pc + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
                    m_pend = 1'b1;
                end else if (w[31:26] == 6'b000010) begin
                    m_tgt = {m_pc[31:28] + 4'd0, w[25:0], 2'b00};
                    m_tgt[31:28] = (m_pc + 32'd4) >> 28;
                    m_pend = 1'b1;
                end
                m_pc = m_pc + 32'd4;
            end
        end
        @(negedge clk);
        check(tag, m_pc);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 in reset", RVEC);
        rst_n = 1'b1;
        #1;
        check("R1 after release", RVEC);
    endtask

    task automatic t_seq;
        for (int i = 0; i < 3; i++) step(NOP, 1'b0, 1'b0, "R2 sequential");
        step(32'h0123_4567, 1'b0, 1'b0, "R2 other opcode");
    endtask

    task automatic t_cond_ignored;
        step(32'h2000_0005, 1'b1, 1'b0, "R6 take on non-branch");
        step(NOP, 1'b0, 1'b0, "R6 no redirect");
    endtask

    task automatic t_branch_fwd;
        logic [31:0] p = m_pc;
        step(br(16'h0003), 1'b1, 1'b0, "R3 fwd slot");
        step(NOP, 1'b0, 1'b0, "R3 fwd target");
        check("R3 fwd target value", p + 32'd16);
    endtask

    task automatic t_branch_back;
        logic [31:0] p = m_pc;
        step(br(16'hFFFE), 1'b1, 1'b0, "R3 back slot");
        step(NOP, 1'b0, 1'b0, "R3 back target");
        check("R3 back target value", p - 32'd4);
    endtask

    task automatic t_not_taken;
        logic [31:0] p = m_pc;
        step(br(16'h0040), 1'b0, 1'b0, "R4 not taken");
        step(NOP, 1'b0, 1'b0, "R4 sequential");
        check("R4 value", p + 32'd8);
    endtask

    task automatic t_jump;
        step(jmp(26'h0000100), 1'b0, 1'b0, "R5 slot");
        step(NOP, 1'b0, 1'b0, "R5 target");
        check("R5 target value", 32'h1000_0400);
    endtask

    task automatic t_slot_xfer;
        logic [31:0] p = m_pc;
        step(br(16'h0008), 1'b1, 1'b0, "R7 slot");
        step(jmp(26'h0000200), 1'b0, 1'b0, "R7 slot jump ignored");
        check("R7 target value", p + 32'd36);
        step(NOP, 1'b0, 1'b0, "R7 after target");
        check("R7 sequential", p + 32'd40);
    endtask

    task automatic t_stall;
        logic [31:0] p = m_pc;
        step(br(16'h0010), 1'b1, 1'b1, "R8 hold");
        step(jmp(26'h0000300), 1'b0, 1'b1, "R8 hold");
        check("R8 frozen", p);
        step(NOP, 1'b0, 1'b0, "R8 no decode under stall");
        check("R8 value", p + 32'd4);
        p = m_pc;
        step(br(16'h0002), 1'b1, 1'b0, "R8 slot");
        step(NOP, 1'b0, 1'b1, "R8 stalled slot");
        step(NOP, 1'b0, 1'b1, "R8 stalled slot");
        check("R8 slot held", p + 32'd4);
        step(NOP, 1'b0, 1'b0, "R8 redirect kept");
        check("R8 target value", p + 32'd12);
        check("R9 aligned", {fetch_pc[31:2], 2'b00});
    endtask

    initial begin
        t_reset();
        t_seq();
        t_cond_ignored();
        t_branch_fwd();
        t_branch_back();
        t_not_taken();
        t_jump();
        t_slot_xfer();
        t_stall();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule